// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects up to 96 level-sensitive interrupt lines, split into three banks of 32, and presents them to a processor as two request outputs, a normal request and a fast request. Each source has its own enable, mask, route-select and 2-bit priority setting. An enabled source that is high latches a pending bit. The pending bit stays set until software writes a one to it. A pending source that is enabled and unmasked is delivered on the fast output if its route bit is set. Otherwise it takes part in priority arbitration for the normal output.

Software sees a plain 32-bit register port with word-aligned offsets and writes that take effect on the clock edge. Reads are combinational. The vector register gives the number of the winning normal source multiplied by four. A vector of zero means no normal request is pending, so source 0 is never delivered through the normal path. The block also holds a base-address word, a 1-bit protection flag and an NMI control word as plain storage for software.

No state machine is needed. All behaviour is per-source flag registers plus one combinational arbitration tree. The only sequencing is the single clock edge between a write or an input level and the updated pending bit.

Top module: `bvic_top`

## Requirements
- R1: While reset is asserted, and immediately after it is released, all enable, mask, select, priority and pending bits are zero, `irq_o` and `fiq_o` are low, and the vector register (offset 0x00) reads zero.
- R2: On each clock edge where source n's input is high and its enable bit is set, source n's pending bit is set. A source whose enable bit is clear does not latch. A latched bit stays set after the input falls.
- R3: A write to a pending register clears every bit written as 1 and leaves bits written as 0 unchanged. Normal pending for bank b is at 0x10+4b and fast pending at 0x20+4b. If the source is still high and enabled at that edge, the set wins and the bit stays pending.
- R4: Clearing an enable bit removes its source from both outputs without clearing the pending bit. Setting the enable bit again brings the request back.
- R5: A mask bit of 1 (registers at 0x50+4b) blocks delivery of its source but does not stop its pending bit from latching. Clearing the mask delivers the held request.
- R6: A source whose select bit is 1 (0x30+4b) latches into the fast pending register and drives `fiq_o`, and it is never reported in the normal pending register or the vector.
- R7: Among sources that are pending, enabled, unmasked and have select clear, the winner has the highest 2-bit priority code (3 highest, 0 lowest). Ties go to the lowest source number. Priority register k sits at 0x80+4k and holds source 16k+j in bits [2j+1:2j].
- R8: The vector register reads the winner's number shifted left by two, or zero when there is no candidate. `irq_o` is high exactly when the vector is nonzero. Source 0 is never the normal winner.
- R9: Base address (0x04, 32 bits), NMI control (0x0C, 32 bits) and protection (0x08, bit 0 only) read back what was written. Response registers (0x60+4b) and unused priority slots read zero, and writes to them are ignored.
- R10: Source n lives in bank n>>5 at bit n&31 of every per-bank register. Enable registers are at 0x40+4b, and all bank registers read back their stored values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Raw level interrupt inputs, bit n is source n |
| reg_wr_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 8 | Word-aligned register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The properties assume the raw inputs and register writes are synchronous to `clk` and stable around its rising edge. They also assume reset is held low across at least one rising edge before any stimulus. The pending-clear property for bank 0 further assumes that a write strobe carries a word-aligned offset, so exactly one register is addressed. The bench changes every input only on the falling edge, pulses reset for several cycles, and uses only aligned offsets. This keeps the stimulus inside those assumptions while still driving set-and-clear on the same edge.

// File: rtl/bvic_pkg.sv
package bvic_pkg;
    localparam int DATA_W = 32;

    // register offsets; per-bank blocks step by one word per bank
    localparam int OFS_VECTOR = 'h00;
    localparam int OFS_BASE   = 'h04;
    localparam int OFS_PROT   = 'h08;
    localparam int OFS_NMI    = 'h0C;
    localparam int OFS_IPEND  = 'h10;
    localparam int OFS_FPEND  = 'h20;
    localparam int OFS_SEL    = 'h30;
    localparam int OFS_EN     = 'h40;
    localparam int OFS_MASK   = 'h50;
    localparam int OFS_PRIO   = 'h80;

    // register group chosen by the upper address nibble
    typedef enum logic [3:0] {
        GRP_CTRL  = 4'h0,
        GRP_IPEND = 4'h1,
        GRP_FPEND = 4'h2,
        GRP_SEL   = 4'h3,
        GRP_EN    = 4'h4,
        GRP_MASK  = 4'h5,
        GRP_RESP  = 4'h6
    } reg_grp_e;
endpackage

// File: rtl/bvic_bank.sv
module bvic_bank
    import bvic_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ipend_o,
    output logic [DATA_W-1:0] fpend_o,
    output logic [DATA_W-1:0] sel_o,
    output logic [DATA_W-1:0] en_o,
    output logic [DATA_W-1:0] mask_o
);
    localparam logic [ADDR_W-1:0] A_IPEND = ADDR_W'(OFS_IPEND + 4*BANK_IDX);
    localparam logic [ADDR_W-1:0] A_FPEND = ADDR_W'(OFS_FPEND + 4*BANK_IDX);
    localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(OFS_SEL   + 4*BANK_IDX);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN    + 4*BANK_IDX);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK  + 4*BANK_IDX);

    logic [DATA_W-1:0] set_i, set_f, clr_i, clr_f;

    always_comb begin
        set_i = src_i & en_o & ~sel_o;
        set_f = src_i & en_o &  sel_o;
        clr_i = (wr_i && addr_i == A_IPEND) ? wdata_i : '0;
        clr_f = (wr_i && addr_i == A_FPEND) ? wdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipend_o <= '0;
            fpend_o <= '0;
            sel_o   <= '0;
            en_o    <= '0;
            mask_o  <= '0;
        end else begin
            // a live enabled level outweighs a clear in the same cycle
            ipend_o <= (ipend_o & ~clr_i) | set_i;
            fpend_o <= (fpend_o & ~clr_f) | set_f;
            if (wr_i && addr_i == A_SEL)  sel_o  <= wdata_i;
            if (wr_i && addr_i == A_EN)   en_o   <= wdata_i;
            if (wr_i && addr_i == A_MASK) mask_o <= wdata_i;
        end
    end
endmodule

// File: rtl/bvic_prio.sv
module bvic_prio
    import bvic_pkg::*;
#(
    parameter int NREGS  = 6,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [NREGS*DATA_W-1:0] prio_o
);
    genvar k;
    for (k = 0; k < NREGS; k++) begin : g_preg
        localparam logic [ADDR_W-1:0] A_REG = ADDR_W'(OFS_PRIO + 4*k);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_o[k*DATA_W +: DATA_W] <= '0;
            else if (wr_i && addr_i == A_REG)
                prio_o[k*DATA_W +: DATA_W] <= wdata_i;
        end
    end
endmodule

// File: rtl/bvic_arbiter.sv
module bvic_arbiter #(
    parameter int NSRC  = 96,
    parameter int PRI_W = 2,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]       cand_i,
    input  logic [NSRC*PRI_W-1:0] pri_i,
    output logic                  valid_o,
    output logic [IDX_W-1:0]      idx_o
);
    logic [PRI_W-1:0] best_pri;

    always_comb begin
        valid_o  = 1'b0;
        idx_o    = '0;
        best_pri = '0;
        // strict compare keeps the lowest number on equal priority
        for (int n = 0; n < NSRC; n++) begin
            if (cand_i[n] && (!valid_o || pri_i[n*PRI_W +: PRI_W] > best_pri)) begin
                valid_o  = 1'b1;
                idx_o    = IDX_W'(n);
                best_pri = pri_i[n*PRI_W +: PRI_W];
            end
        end
    end
endmodule

// File: rtl/bvic_top.sv
module bvic_top
    import bvic_pkg::*;
#(
    parameter int BANKS  = 3,
    parameter int PRI_W  = 2,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BANKS*32-1:0]    src_i,
    input  logic                   reg_wr_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [31:0]            reg_wdata_i,
    output logic [31:0]            reg_rdata_o,
    output logic                   irq_o,
    output logic                   fiq_o
);
    localparam int NSRC     = BANKS * DATA_W;
    localparam int PER_REG  = DATA_W / PRI_W;
    localparam int PRI_REGS = (NSRC + PER_REG - 1) / PER_REG;
    localparam int IDX_W    = $clog2(NSRC);

    logic [DATA_W-1:0] ipend_b [BANKS];
    logic [DATA_W-1:0] fpend_b [BANKS];
    logic [DATA_W-1:0] sel_b   [BANKS];
    logic [DATA_W-1:0] en_b    [BANKS];
    logic [DATA_W-1:0] mask_b  [BANKS];
    logic [NSRC-1:0]   ipend_all, fpend_all, sel_all, en_all, mask_all;
    logic [NSRC-1:0]   irq_cand;
    logic [PRI_REGS*DATA_W-1:0] prio_all;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [DATA_W-1:0] base_q, nmi_q;
    logic              prot_q;

    genvar b;
    for (b = 0; b < BANKS; b++) begin : g_bank
        bvic_bank #(.BANK_IDX(b), .ADDR_W(ADDR_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[b*DATA_W +: DATA_W]),
            .wr_i    (reg_wr_i),
            .addr_i  (reg_addr_i),
            .wdata_i (reg_wdata_i),
            .ipend_o (ipend_b[b]),
            .fpend_o (fpend_b[b]),
            .sel_o   (sel_b[b]),
            .en_o    (en_b[b]),
            .mask_o  (mask_b[b])
        );
        assign ipend_all[b*DATA_W +: DATA_W] = ipend_b[b];
        assign fpend_all[b*DATA_W +: DATA_W] = fpend_b[b];
        assign sel_all[b*DATA_W +: DATA_W]   = sel_b[b];
        assign en_all[b*DATA_W +: DATA_W]    = en_b[b];
        assign mask_all[b*DATA_W +: DATA_W]  = mask_b[b];
    end

    bvic_prio #(.NREGS(PRI_REGS), .ADDR_W(ADDR_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .prio_o  (prio_all)
    );

    // source 0 is reserved: a zero vector means nothing pending
    assign irq_cand = ipend_all & en_all & ~mask_all & ~sel_all & ~NSRC'(1);
    assign fiq_o    = |(fpend_all & en_all & ~mask_all & sel_all);

    bvic_arbiter #(.NSRC(NSRC), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_arb (
        .cand_i  (irq_cand),
        .pri_i   (prio_all[NSRC*PRI_W-1:0]),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );
    assign irq_o = win_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            nmi_q  <= '0;
            prot_q <= 1'b0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == ADDR_W'(OFS_BASE)) base_q <= reg_wdata_i;
            if (reg_addr_i == ADDR_W'(OFS_NMI))  nmi_q  <= reg_wdata_i;
            if (reg_addr_i == ADDR_W'(OFS_PROT)) prot_q <= reg_wdata_i[0];
        end
    end

    always_comb begin
        logic [1:0] slot;
        slot        = reg_addr_i[3:2];
        reg_rdata_o = '0;
        if (reg_addr_i[7]) begin
            for (int k = 0; k < PRI_REGS; k++)
                if (reg_addr_i[6:2] == 5'(k))
                    reg_rdata_o = prio_all[k*DATA_W +: DATA_W];
        end else begin
            unique case (reg_grp_e'(reg_addr_i[7:4]))
                GRP_CTRL: begin
                    unique case (slot)
                        2'd0: reg_rdata_o = win_valid ? DATA_W'({win_idx, 2'b00}) : '0;
                        2'd1: reg_rdata_o = base_q;
                        2'd2: reg_rdata_o = DATA_W'(prot_q);
                        2'd3: reg_rdata_o = nmi_q;
                    endcase
                end
                GRP_IPEND, GRP_FPEND, GRP_SEL, GRP_EN, GRP_MASK: begin
                    for (int i = 0; i < BANKS; i++) begin
                        if (slot == 2'(i)) begin
                            case (reg_grp_e'(reg_addr_i[7:4]))
                                GRP_IPEND: reg_rdata_o = ipend_b[i];
                                GRP_FPEND: reg_rdata_o = fpend_b[i];
                                GRP_SEL:   reg_rdata_o = sel_b[i];
                                GRP_EN:    reg_rdata_o = en_b[i];
                                default:   reg_rdata_o = mask_b[i];
                            endcase
                        end
                    end
                end
                default: reg_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/bvic_checker.sv
module bvic_checker #(
    parameter int NSRC   = 96,
    parameter int IDX_W  = 7,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [NSRC-1:0]   ipend,
    input logic [NSRC-1:0]   fpend,
    input logic [NSRC-1:0]   en,
    input logic [NSRC-1:0]   mask,
    input logic [NSRC-1:0]   sel,
    input logic [IDX_W-1:0]  win_idx
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_o && !fiq_o && ipend == '0 && fpend == '0));

    a_r2_latch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipend & ~$past(ipend)) & ~$past(src_i & en & ~sel)) == '0);

    a_r3_clear_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr_i && reg_addr_i == ADDR_W'('h10)) |->
        (ipend[31:0] & $past(reg_wdata_i) & ~$past(src_i[31:0] & en[31:0] & ~sel[31:0])) == '0);

    a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(ipend & en & ~mask & ~sel));

    a_r6_fiq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> |(fpend & en & ~mask & sel));

    a_r8_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ipend[win_idx] && en[win_idx] && !mask[win_idx] && win_idx != '0));
endmodule

bind bvic_top bvic_checker #(.NSRC(NSRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .ipend       (ipend_all),
    .fpend       (fpend_all),
    .en          (en_all),
    .mask        (mask_all),
    .sel         (sel_all),
    .win_idx     (win_idx)
);

// File: tb/bvic_top_tb.sv
module bvic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    bvic_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    // {offset, write data, expected readback}
    localparam logic [71:0] TBL [10] = '{
        {8'h04, 32'hDEADBEEF, 32'hDEADBEEF},
        {8'h08, 32'hFFFFFFFF, 32'h00000001},
        {8'h0C, 32'h12345678, 32'h12345678},
        {8'h44, 32'hA5A5A5A5, 32'hA5A5A5A5},
        {8'h58, 32'h0F0F0000, 32'h0F0F0000},
        {8'h34, 32'h00FF0000, 32'h00FF0000},
        {8'h84, 32'h89ABCDEF, 32'h89ABCDEF},
        {8'h94, 32'hFFFF0001, 32'hFFFF0001},
        {8'h64, 32'hFFFFFFFF, 32'h00000000},
        {8'hA0, 32'hFFFFFFFF, 32'h00000000}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0; wr = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();
        rd_reg(8'h00, v); chk("R1 vector after reset", v, 32'h0);
        chk("R1 irq/fiq after reset", {30'h0, irq, fiq}, 32'h0);
        rd_reg(8'h40, v); chk("R1 enable after reset", v, 32'h0);

        // register storage and bank mapping walk (R9, R10)
        foreach (TBL[i]) begin
            wr_reg(TBL[i][71:64], TBL[i][63:32]);
            rd_reg(TBL[i][71:64], v);
            chk($sformatf("R9/R10 readback @%h", TBL[i][71:64]), v, TBL[i][31:0]);
        end

        do_reset();
        // R2: disabled source does not latch
        src[5] = 1'b1; step();
        rd_reg(8'h10, v); chk("R2 disabled no latch", v, 32'h0);
        wr_reg(8'h40, 32'h0000_0021);   // enable sources 0 and 5
        step();
        src[5] = 1'b0; step();
        rd_reg(8'h10, v); chk("R2 latched and held", v, 32'h20);
        rd_reg(8'h00, v); chk("R8 vector of source 5", v, 32'd20);
        chk("R8 irq high", {31'h0, irq}, 32'h1);

        // R3: zero write keeps, one write clears
        wr_reg(8'h10, 32'h0);
        rd_reg(8'h10, v); chk("R3 zero write no effect", v, 32'h20);
        wr_reg(8'h10, 32'h20);
        rd_reg(8'h10, v); chk("R3 one write clears", v, 32'h0);
        chk("R8 irq low when none", {31'h0, irq}, 32'h0);

        // R3: live input wins over clear
        src[5] = 1'b1; step();
        wr_reg(8'h10, 32'h20);
        rd_reg(8'h10, v); chk("R3 set wins over clear", v, 32'h20);
        src[5] = 1'b0; step();
        wr_reg(8'h10, 32'hFFFF_FFFF);

        // R5: mask blocks delivery but not latching
        wr_reg(8'h50, 32'h20);
        src[5] = 1'b1; step(); src[5] = 1'b0;
        rd_reg(8'h10, v); chk("R5 masked still latches", v, 32'h20);
        chk("R5 masked no irq", {31'h0, irq}, 32'h0);
        wr_reg(8'h50, 32'h0);
        chk("R5 unmask delivers", {31'h0, irq}, 32'h1);

        // R4: enable drop hides, restore brings back
        wr_reg(8'h40, 32'h01);
        chk("R4 disabled hides irq", {31'h0, irq}, 32'h0);
        rd_reg(8'h10, v); chk("R4 pending kept", v, 32'h20);
        wr_reg(8'h40, 32'h21);
        rd_reg(8'h00, v); chk("R4 re-enable restores", v, 32'd20);
        wr_reg(8'h10, 32'h20);

        // R7: priority and tie order across banks (R10 mapping)
        wr_reg(8'h88, 32'h0003_0004);   // src 40 -> 3, src 33 -> 1
        wr_reg(8'h90, 32'h0000_3000);   // src 70 -> 3
        wr_reg(8'h44, 32'h0000_0102);   // src 33, 40
        wr_reg(8'h48, 32'h0000_0040);   // src 70
        src[33] = 1'b1; src[40] = 1'b1; src[70] = 1'b1;
        step();
        src[33] = 1'b0; src[40] = 1'b0; src[70] = 1'b0;
        rd_reg(8'h00, v); chk("R7 high prio tie lowest", v, 32'd160);
        wr_reg(8'h14, 32'h100);
        rd_reg(8'h00, v); chk("R7 next is 70", v, 32'd280);
        wr_reg(8'h18, 32'hFFFF_FFFF);
        rd_reg(8'h00, v); chk("R7 low prio 33 last", v, 32'd132);
        wr_reg(8'h14, 32'hFFFF_FFFF);

        // R6: select routes to fast path
        wr_reg(8'h30, 32'h08);
        wr_reg(8'h40, 32'h09);
        src[3] = 1'b1; step(); src[3] = 1'b0;
        chk("R6 fiq high", {30'h0, irq, fiq}, 32'h1);
        rd_reg(8'h20, v); chk("R6 fast pending", v, 32'h08);
        rd_reg(8'h10, v); chk("R6 not in normal pending", v, 32'h0);
        wr_reg(8'h20, 32'h08);
        chk("R6 fast clear", {31'h0, fiq}, 32'h0);

        // R8: source 0 never delivered as a vector
        src[0] = 1'b1; step(); src[0] = 1'b0;
        rd_reg(8'h10, v); chk("R8 source 0 pending", v, 32'h01);
        rd_reg(8'h00, v); chk("R8 source 0 no vector", v, 32'h0);
        chk("R8 source 0 no irq", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule